// File: doc/BRIEF.md
# Bus-Master DMA Register Window with Interrupt Combiner

This block is the host-visible register window of a two-channel IDE bus-master DMA engine. Each channel presents four byte registers: a command byte, a status byte, a per-channel timing byte, and a mode register that both channels share. The host picks the channel and the byte offset, and reads return at once from the selected register. A write takes effect at the next clock edge. The command byte drives the engine's start and direction controls. The status byte gathers engine activity, engine errors and channel interrupt events.

Both ATA channels drive an interrupt level into the block, and each channel can also report that its device-control register disables interrupts. A raising level sets a sticky flag in the shared mode register. Each flag is gated by a host-writable block bit. The unblocked flags are ORed into one level-sensitive interrupt output. A variant input selects the extended register set. When it is low, the mode and timing offsets do not exist: they read as all ones and writes to them are dropped.

Top module: `busmaster_regs`

## Requirements
- R1: After reset, every register reads 0x00 on both channels, `irq_o` is low, and the start and direction outputs are low.
- R2: A write to offset 0 stores the whole command byte, and offset 0 reads it back. Bit 0 drives `cmd_start` and bit 3 drives `cmd_dev_rd` of that channel. The other channel's command byte is not affected.
- R3: Bit 0 of status (offset 2) is read-only. One cycle later it shows `eng_active` of that channel, and host writes do not change it.
- R4: Status bits 1 and 2 are write-1-to-clear. Writing 1 clears the bit, and writing 0 leaves it unchanged. Bit 1 is set by `eng_err`, and bit 2 is set by a channel interrupt event. In the same cycle, a setting event wins over a clear.
- R5: Status bits 5 and 6 are plain read/write. All other status bits read 0.
- R6: A channel interrupt event happens when that channel's level is high, its disable input is low, and its mode flag is clear. The event sets the channel's flag in the mode register (bit 2 for channel 0, bit 3 for channel 1) and status bit 2 of that channel. A level that is high while disabled causes no event.
- R7: A channel interrupt level of 0 clears that channel's mode flag. The status bits are not affected.
- R8: Offset 1 maps to one mode register shared by both channel windows. Host writes there change only the block bits: bit 4 for channel 0 and bit 5 for channel 1. The flags are unchanged, and bits 0, 1, 6 and 7 read 0.
- R9: `irq_o` equals (flag0 AND NOT block0) OR (flag1 AND NOT block1), using the current register contents.
- R10: Offset 3 is a read/write timing byte with a separate register for each channel.
- R11: When `ext_en` is low, offsets 1 and 3 read 0xFF, writes to them are ignored, and the block bits do not gate `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| ext_en | input | 1 | 1 = extended registers (mode, timing) present |
| acc_chan | input | 1 | Channel window selected by the host |
| acc_ofs | input | 2 | Byte offset: 0 command, 1 mode, 2 status, 3 timing |
| acc_wr | input | 1 | Host write strobe |
| acc_wdata | input | 8 | Host write data |
| acc_rdata | output | 8 | Read data of the selected register |
| eng_active | input | 2 | Per-channel engine busy indication |
| eng_err | input | 2 | Per-channel engine error pulse |
| ch_irq_lvl | input | 2 | Per-channel interrupt level from the ATA channel |
| ch_irq_off | input | 2 | Per-channel interrupt disable from device control |
| cmd_start | output | 2 | Command bit 0 of each channel |
| cmd_dev_rd | output | 2 | Command bit 3 of each channel (transfer from device) |
| irq_o | output | 1 | Combined level-sensitive interrupt |

## Verification
The embedded properties check the following on every cycle:
- the read-only activity bit follows the engine;
- write-1-to-clear removes a status bit when no event competes;
- the read/write status bits take the written value;
- an event sets its flag, and a low level clears it;
- an unblocked event raises `irq_o`;
- block and timing writes are ignored in the basic variant.

Only the bench scenarios show the following:
- the sharing of the mode register between the two channel windows;
- the independence of the per-channel command and timing bytes;
- the suppression of events by the disable input;
- the all-ones reads of the missing registers;
- that the stored values survive a period in the basic variant.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
  localparam int DW    = 8;
  localparam int OFS_W = 2;
  localparam int NCH   = 2;

  typedef enum logic [OFS_W-1:0] {
    OFS_CMD  = 2'd0,
    OFS_MODE = 2'd1,
    OFS_STAT = 2'd2,
    OFS_TIME = 2'd3
  } bmr_ofs_e;

  localparam int CMD_START_BIT = 0;
  localparam int CMD_DIR_BIT   = 3;
  localparam int ST_ACT_BIT    = 0;
  localparam int ST_ERR_BIT    = 1;
  localparam int ST_IRQ_BIT    = 2;
  localparam int ST_RW_LSB     = 5;
  localparam int ST_RW_MSB     = 6;
  localparam int MODE_FLAG_LSB = 2;
  localparam int MODE_BLK_LSB  = 4;

  localparam logic [DW-1:0] ABSENT_RD = '1;
endpackage

// File: rtl/bmr_chan.sv
module bmr_chan
  import bmr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_en,
  input  logic          wr_en,
  input  logic [OFS_W-1:0] wr_ofs,
  input  logic [DW-1:0] wr_data,
  input  logic          eng_active,
  input  logic          eng_err,
  input  logic          irq_evt,
  output logic [DW-1:0] cmd_q,
  output logic [DW-1:0] stat_q,
  output logic [DW-1:0] time_q
);
  logic          cmd_en, time_en, stat_w;
  logic [DW-1:0] stat_d;
  logic          keep_err, keep_irq;

  always_comb begin
    cmd_en   = wr_en && (wr_ofs == OFS_CMD);
    time_en  = wr_en && ext_en && (wr_ofs == OFS_TIME);
    stat_w   = wr_en && (wr_ofs == OFS_STAT);
    keep_err = stat_q[ST_ERR_BIT] & ~(stat_w & wr_data[ST_ERR_BIT]);
    keep_irq = stat_q[ST_IRQ_BIT] & ~(stat_w & wr_data[ST_IRQ_BIT]);
    stat_d   = '0;
    stat_d[ST_ACT_BIT] = eng_active;
    stat_d[ST_ERR_BIT] = keep_err | eng_err;
    stat_d[ST_IRQ_BIT] = keep_irq | irq_evt;
    stat_d[ST_RW_MSB:ST_RW_LSB] = stat_w ? wr_data[ST_RW_MSB:ST_RW_LSB]
                                         : stat_q[ST_RW_MSB:ST_RW_LSB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      time_q <= '0;
      stat_q <= '0;
    end else begin
      if (cmd_en)  cmd_q  <= wr_data;
      if (time_en) time_q <= wr_data;
      stat_q <= stat_d;
    end
  end

  p_active_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (stat_q[ST_ACT_BIT] == $past(eng_active)));

  p_w1c_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_w && wr_data[ST_IRQ_BIT] && !irq_evt) |=> !stat_q[ST_IRQ_BIT]);

  p_rw_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_w |=> (stat_q[ST_RW_MSB:ST_RW_LSB] == $past(wr_data[ST_RW_MSB:ST_RW_LSB])));

  p_time_basic_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_en && wr_en && wr_ofs == OFS_TIME) |=> $stable(time_q));
endmodule

// File: rtl/bmr_irq_merge.sv
module bmr_irq_merge
  import bmr_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ext_en,
  input  logic [NCH-1:0] ch_lvl,
  input  logic [NCH-1:0] ch_off,
  input  logic           blk_wr,
  input  logic [NCH-1:0] blk_wdata,
  output logic [NCH-1:0] flag_q,
  output logic [NCH-1:0] blk_q,
  output logic [NCH-1:0] irq_evt,
  output logic           irq_o
);
  logic [NCH-1:0] raise, flag_d, blk_eff;
  logic           blk_en;

  always_comb begin
    raise   = ch_lvl & ~ch_off;
    irq_evt = raise & ~flag_q;
    for (int c = 0; c < NCH; c++) begin
      if (raise[c])       flag_d[c] = 1'b1;
      else if (!ch_lvl[c]) flag_d[c] = 1'b0;
      else                flag_d[c] = flag_q[c];
    end
    blk_en  = blk_wr && ext_en;
    blk_eff = blk_q & {NCH{ext_en}};
    irq_o   = |(flag_q & ~blk_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      blk_q  <= '0;
    end else begin
      flag_q <= flag_d;
      if (blk_en) blk_q <= blk_wdata;
    end
  end

  p_evt_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_evt != '0) |=> ((flag_q & $past(irq_evt)) == $past(irq_evt)));

  p_low_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (~ch_lvl != '0) |=> ((flag_q & ~$past(ch_lvl)) == '0));

  p_unblocked_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(irq_evt & ~blk_q)) && !blk_wr) |=> irq_o);

  p_blk_basic_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_en && blk_wr) |=> $stable(blk_q));
endmodule

// File: rtl/busmaster_regs.sv
module busmaster_regs
  import bmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_en,
  input  logic       acc_chan,
  input  logic [1:0] acc_ofs,
  input  logic       acc_wr,
  input  logic [7:0] acc_wdata,
  output logic [7:0] acc_rdata,
  input  logic [1:0] eng_active,
  input  logic [1:0] eng_err,
  input  logic [1:0] ch_irq_lvl,
  input  logic [1:0] ch_irq_off,
  output logic [1:0] cmd_start,
  output logic [1:0] cmd_dev_rd,
  output logic       irq_o
);
  logic [1:0]     rst_pipe;
  logic           rst_sync_n;
  logic [DW-1:0]  cmd_q  [NCH];
  logic [DW-1:0]  stat_q [NCH];
  logic [DW-1:0]  time_q [NCH];
  logic [NCH-1:0] flag_q, blk_q, irq_evt;
  logic [DW-1:0]  mode_rd;
  logic           mode_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    bmr_chan u_chan (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .ext_en     (ext_en),
      .wr_en      (acc_wr && (acc_chan == c[0])),
      .wr_ofs     (acc_ofs),
      .wr_data    (acc_wdata),
      .eng_active (eng_active[c]),
      .eng_err    (eng_err[c]),
      .irq_evt    (irq_evt[c]),
      .cmd_q      (cmd_q[c]),
      .stat_q     (stat_q[c]),
      .time_q     (time_q[c])
    );
    assign cmd_start[c]  = cmd_q[c][CMD_START_BIT];
    assign cmd_dev_rd[c] = cmd_q[c][CMD_DIR_BIT];
  end

  assign mode_wr = acc_wr && (acc_ofs == OFS_MODE);

  bmr_irq_merge u_merge (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ext_en    (ext_en),
    .ch_lvl    (ch_irq_lvl),
    .ch_off    (ch_irq_off),
    .blk_wr    (mode_wr),
    .blk_wdata (acc_wdata[MODE_BLK_LSB +: NCH]),
    .flag_q    (flag_q),
    .blk_q     (blk_q),
    .irq_evt   (irq_evt),
    .irq_o     (irq_o)
  );

  always_comb begin
    mode_rd = '0;
    mode_rd[MODE_FLAG_LSB +: NCH] = flag_q;
    mode_rd[MODE_BLK_LSB +: NCH]  = blk_q;
    case (acc_ofs)
      OFS_CMD:  acc_rdata = cmd_q[acc_chan];
      OFS_MODE: acc_rdata = ext_en ? mode_rd : ABSENT_RD;
      OFS_STAT: acc_rdata = stat_q[acc_chan];
      default:  acc_rdata = ext_en ? time_q[acc_chan] : ABSENT_RD;
    endcase
  end

  p_flags_host_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_wr && ch_irq_lvl == 2'b11 && ch_irq_off == 2'b11) |=> $stable(flag_q));
endmodule

// File: tb/busmaster_regs_bench.sv
`timescale 1ns/100ps
module busmaster_regs_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ext_en;
  logic       acc_chan;
  logic [1:0] acc_ofs;
  logic       acc_wr;
  logic [7:0] acc_wdata;
  logic [7:0] acc_rdata;
  logic [1:0] eng_active, eng_err, ch_irq_lvl, ch_irq_off;
  logic [1:0] cmd_start, cmd_dev_rd;
  logic       irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];
  event  ev_chk;

  always #2 clk = ~clk;

  busmaster_regs u_busmaster_regs (
    .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .acc_chan(acc_chan),
    .acc_ofs(acc_ofs), .acc_wr(acc_wr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .eng_active(eng_active), .eng_err(eng_err),
    .ch_irq_lvl(ch_irq_lvl), .ch_irq_off(ch_irq_off),
    .cmd_start(cmd_start), .cmd_dev_rd(cmd_dev_rd), .irq_o(irq_o)
  );

  // monitor: pops expected items and compares with the design's outputs
  initial begin
    forever begin
      @(ev_chk);
      #0.5;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          0:       act = acc_rdata;
          1:       act = {7'd0, irq_o};
          default: act = {4'd0, cmd_start, cmd_dev_rd};
        endcase
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic c, input logic [1:0] o, input logic [7:0] d);
    acc_chan = c; acc_ofs = o; acc_wdata = d; acc_wr = 1'b1;
    @(negedge clk);
    acc_wr = 1'b0;
  endtask

  task automatic push(input int k, input logic [7:0] e, input string t);
    item_t it;
    it.kind = k; it.exp = e; it.tag = t;
    sb_q.push_back(it);
    ->ev_chk;
    #1;
    @(negedge clk);
  endtask

  task automatic rd(input logic c, input logic [1:0] o, input logic [7:0] e, input string t);
    acc_chan = c; acc_ofs = o;
    push(0, e, t);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ext_en = 1'b1; acc_chan = 1'b0; acc_ofs = 2'd0;
    acc_wr = 1'b0; acc_wdata = 8'd0; eng_active = 2'b00; eng_err = 2'b00;
    ch_irq_lvl = 2'b00; ch_irq_off = 2'b00;
    repeat (5) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R1 reset state
    for (int c = 0; c < 2; c++)
      for (int o = 0; o < 4; o++) rd(c[0], o[1:0], 8'h00, "R1 reset reg");
    push(1, 8'h00, "R1 irq after reset");
    push(2, 8'h00, "R1 cmd pins after reset");

    // R2 command byte
    wr(1'b0, 2'd0, 8'h09);
    rd(1'b0, 2'd0, 8'h09, "R2 cmd readback ch0");
    rd(1'b1, 2'd0, 8'h00, "R2 cmd ch1 untouched");
    push(2, 8'h05, "R2 start/dir pins");

    // R3 active bit read-only
    wr(1'b0, 2'd2, 8'h01);
    rd(1'b0, 2'd2, 8'h00, "R3 host cannot set active");
    eng_active = 2'b01; tick();
    rd(1'b0, 2'd2, 8'h01, "R3 active follows engine");
    wr(1'b0, 2'd2, 8'h00);
    rd(1'b0, 2'd2, 8'h01, "R3 host cannot clear active");
    eng_active = 2'b00; tick();
    rd(1'b0, 2'd2, 8'h00, "R3 active drops");

    // R4 / R6 / R9 error and interrupt status
    eng_err = 2'b01; tick(); eng_err = 2'b00;
    rd(1'b0, 2'd2, 8'h02, "R4 error set");
    ch_irq_lvl = 2'b01; tick();
    rd(1'b0, 2'd2, 8'h06, "R6 event sets status bit2");
    rd(1'b0, 2'd1, 8'h04, "R6 event sets flag0");
    push(1, 8'h01, "R9 unblocked flag0 raises irq");
    wr(1'b0, 2'd2, 8'h02);
    rd(1'b0, 2'd2, 8'h04, "R4 w1c error only");
    wr(1'b0, 2'd2, 8'h04);
    rd(1'b0, 2'd2, 8'h00, "R4 w1c irq bit");

    // R5 read/write bits
    wr(1'b0, 2'd2, 8'h60);
    rd(1'b0, 2'd2, 8'h60, "R5 rw bits set");
    wr(1'b0, 2'd2, 8'h20);
    rd(1'b0, 2'd2, 8'h20, "R5 rw bit6 cleared");

    // R8 / R9 shared mode register and blocking
    wr(1'b0, 2'd1, 8'hFF);
    rd(1'b0, 2'd1, 8'h34, "R8 host writes only block bits");
    push(1, 8'h00, "R9 blocked flag0");
    wr(1'b1, 2'd1, 8'h00);
    rd(1'b0, 2'd1, 8'h04, "R8 shared via ch1 window");
    rd(1'b1, 2'd1, 8'h04, "R8 same value in ch1 window");
    push(1, 8'h01, "R9 unblocked again");

    // R7 level low clears flag only
    ch_irq_lvl = 2'b00; tick();
    rd(1'b0, 2'd1, 8'h00, "R7 flag0 cleared");
    push(1, 8'h00, "R7 irq drops");
    rd(1'b0, 2'd2, 8'h20, "R7 status untouched");

    // R6 suppression by disable
    ch_irq_off = 2'b10; ch_irq_lvl = 2'b10; tick();
    rd(1'b0, 2'd1, 8'h00, "R6 disabled level no flag");
    rd(1'b1, 2'd2, 8'h00, "R6 disabled level no status");
    push(1, 8'h00, "R6 disabled no irq");
    ch_irq_off = 2'b00; tick();
    rd(1'b0, 2'd1, 8'h08, "R6 flag1 after enable");
    rd(1'b1, 2'd2, 8'h04, "R6 status ch1 bit2");
    push(1, 8'h01, "R9 flag1 irq");
    ch_irq_lvl = 2'b00; tick();
    rd(1'b0, 2'd1, 8'h00, "R7 flag1 cleared");

    // R9 block channel 1 only
    wr(1'b0, 2'd1, 8'h20);
    ch_irq_lvl = 2'b10; tick();
    rd(1'b0, 2'd1, 8'h28, "R9 flag1 with block1");
    push(1, 8'h00, "R9 block1 masks irq");
    ch_irq_lvl = 2'b11; tick();
    rd(1'b0, 2'd1, 8'h2C, "R9 both flags");
    push(1, 8'h01, "R9 flag0 passes");
    ch_irq_lvl = 2'b00; tick();
    push(1, 8'h00, "R9 all low");
    wr(1'b0, 2'd1, 8'h00);

    // R10 timing per channel
    wr(1'b0, 2'd3, 8'h5A);
    wr(1'b1, 2'd3, 8'hC3);
    rd(1'b0, 2'd3, 8'h5A, "R10 timing ch0");
    rd(1'b1, 2'd3, 8'hC3, "R10 timing ch1");

    // R11 basic variant
    ext_en = 1'b0;
    rd(1'b0, 2'd1, 8'hFF, "R11 mode absent");
    rd(1'b1, 2'd3, 8'hFF, "R11 timing absent");
    rd(1'b0, 2'd0, 8'h09, "R11 cmd still present");
    wr(1'b0, 2'd3, 8'h11);
    wr(1'b0, 2'd1, 8'h30);
    ext_en = 1'b1;
    rd(1'b0, 2'd3, 8'h5A, "R11 timing write ignored");
    rd(1'b0, 2'd1, 8'h00, "R11 mode write ignored");

    // R1 reset clears again
    rst_n = 1'b0; tick(); rst_n = 1'b1;
    repeat (3) tick();
    rd(1'b0, 2'd0, 8'h00, "R1 cmd cleared");
    rd(1'b0, 2'd2, 8'h00, "R1 status cleared");
    rd(1'b1, 2'd3, 8'h00, "R1 timing cleared");
    push(2, 8'h00, "R1 pins cleared");

    tick();
    done = 1;
    summary();
    $finish;
  end
endmodule